// File: doc/BRIEF.md
# Indexed Display Register Port with Hidden Pixel-Mode Register

This block is the byte-wide register front end of a VGA-style display controller. A host bus makes 8-bit reads and writes at small byte offsets. Three register groups each sit behind a pair of ports: the sequencer, the CRT controller and the graphics controller. A write to a group's index port selects a register in that group. A write to its data port stores into the selected register, and a read from its data port returns that register's contents. Every register reads back exactly the byte last written to it, so software can safely do read-modify-write.

The palette mask port holds a mask byte. It also gives access to a hidden pixel-mode byte. Four consecutive bus accesses that are all reads of the mask port arm an unlock. The next write to that port then lands in the pixel-mode register instead of the mask, and the unlock clears. Sequencer register 7 carries a pixel-depth code in its low five bits. The block decodes this code into a 2-bit depth for the pixel pipeline and flags codes it does not recognise.

Top module: `disp_regport`

## Requirements
- R1: The index ports are at byte offsets 0x04 (sequencer), 0x14 (CRT controller) and 0x0E (graphics controller). A write to an index port stores all 8 bits, and a read from that port returns them.
- R2: The data ports are at offsets 0x05, 0x15 and 0x0F. A data write stores into the register chosen by the group's index, and a data read returns that register's value. The group sizes are 8 (sequencer), 32 (CRT controller) and 16 (graphics controller). Each register is independent and reads back exactly what was written.
- R3: If a group's index is at or beyond the group size, a data write has no effect on any register and a data read returns 0x00.
- R4: After four consecutive accesses that are all reads of offset 0x06, the next write to 0x06 updates the pixel-mode output and leaves the mask output unchanged. With fewer than four such reads, a write to 0x06 updates the mask and leaves the pixel-mode output unchanged.
- R5: Any write, or any read of an offset other than 0x06, clears the read count and any armed state. Idle bus cycles leave the count unchanged.
- R6: The write that reaches the pixel-mode register also clears the unlock, so the following write to 0x06 goes to the mask again.
- R7: While the unlock is armed, reads of 0x06 return the pixel-mode value and keep the unlock armed. Otherwise reads of 0x06 return the mask.
- R8: The depth output follows the low five bits of sequencer register 7. The code 0x11 gives depth 0 (8 bpp), 0x17 gives 1 (16 bpp), 0x15 gives 2 (24 bpp) and 0x19 gives 3 (32 bpp). Bits 7..5 of the register do not affect the decode. The output changes in the cycle after the write.
- R9: For any other low-five-bit value, the error output is 1 and the depth output is 0. For the four valid codes, the error output is 0.
- R10: After reset, every register, index, mask and pixel-mode value is 0x00, the unlock is idle and the error output is 1.
- R11: Reads of offsets that carry no port return 0x00. The read data is 0x00 in any cycle without a read.
- R12: A cycle with both read and write strobes high acts as a write alone. It returns 0x00 on the read data and counts as a write for the unlock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W (5) | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the same cycle as bus_rd |
| pal_mask | output | 8 | Current palette mask byte |
| pix_mode | output | 8 | Current hidden pixel-mode byte |
| pix_depth | output | 2 | Decoded pixel depth: 0=8, 1=16, 2=24, 3=32 bpp |
| depth_err | output | 1 | Sequencer register 7 holds no valid depth code |

## Verification
The hardest state to reach is the armed unlock. It needs an unbroken run of mask-port reads, and the run must be broken or continued in every possible way. The stimulus sweeps the number of mask reads from zero to six before a mask-port write. It also inserts breakers at the third read: a read of another port, a write elsewhere, a cycle with both strobes high, and plain idle cycles. The expected target of the write, mask or pixel-mode register, comes from the read count alone. The depth decoder is swept over all 256 values of sequencer register 7.

// File: rtl/disp_regport_pkg.sv
package disp_regport_pkg;

  localparam int DW = 8;

  localparam logic [7:0] OFS_SEQ_IDX = 8'h04;
  localparam logic [7:0] OFS_SEQ_DAT = 8'h05;
  localparam logic [7:0] OFS_MASK    = 8'h06;
  localparam logic [7:0] OFS_GFX_IDX = 8'h0E;
  localparam logic [7:0] OFS_GFX_DAT = 8'h0F;
  localparam logic [7:0] OFS_CRT_IDX = 8'h14;
  localparam logic [7:0] OFS_CRT_DAT = 8'h15;

  localparam logic [4:0] CODE_8BPP  = 5'h11;
  localparam logic [4:0] CODE_16BPP = 5'h17;
  localparam logic [4:0] CODE_24BPP = 5'h15;
  localparam logic [4:0] CODE_32BPP = 5'h19;

  typedef enum logic [2:0] {
    PORT_NONE,
    PORT_SEQ_IDX,
    PORT_SEQ_DAT,
    PORT_CRT_IDX,
    PORT_CRT_DAT,
    PORT_GFX_IDX,
    PORT_GFX_DAT,
    PORT_MASK
  } port_e;

  typedef enum logic [1:0] {
    DEPTH_8  = 2'd0,
    DEPTH_16 = 2'd1,
    DEPTH_24 = 2'd2,
    DEPTH_32 = 2'd3
  } depth_e;

  function automatic port_e decode_port(input logic [7:0] ofs);
    port_e p;
    case (ofs)
      OFS_SEQ_IDX: p = PORT_SEQ_IDX;
      OFS_SEQ_DAT: p = PORT_SEQ_DAT;
      OFS_CRT_IDX: p = PORT_CRT_IDX;
      OFS_CRT_DAT: p = PORT_CRT_DAT;
      OFS_GFX_IDX: p = PORT_GFX_IDX;
      OFS_GFX_DAT: p = PORT_GFX_DAT;
      OFS_MASK:    p = PORT_MASK;
      default:     p = PORT_NONE;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/disp_rst_sync.sv
module disp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/disp_idx_bank.sv
module disp_idx_bank #(
  parameter int N   = 8,
  parameter int DW  = 8,
  parameter int TAP = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          idx_we,
  input  logic          dat_we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] idx_q,
  output logic [DW-1:0] dat_q,
  output logic [DW-1:0] tap_q
);

  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [DW-1:0] idx_d;
  logic          idx_en;
  logic          in_range;
  logic [IW-1:0] slot;
  logic [DW-1:0] rd_arr [N];

  // index register: next state and enable
  always_comb begin
    idx_en = idx_we;
    idx_d  = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_d;
    end
  end

  always_comb begin
    in_range = (int'(idx_q) < N);
    slot     = idx_q[IW-1:0];
  end

  // one storage byte per slot, each with its own clock enable
  for (genvar i = 0; i < N; i++) begin : g_slot
    logic          slot_en;
    logic [DW-1:0] slot_d;
    logic [DW-1:0] slot_q;

    always_comb begin
      slot_en = dat_we && in_range && (slot == IW'(i));
      slot_d  = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q <= '0;
      end else if (slot_en) begin
        slot_q <= slot_d;
      end
    end

    assign rd_arr[i] = slot_q;
  end

  always_comb begin
    if (in_range) begin
      dat_q = rd_arr[slot];
    end else begin
      dat_q = '0;
    end
  end

  assign tap_q = rd_arr[TAP];

endmodule

// File: rtl/disp_mask_unit.sv
module disp_mask_unit #(
  parameter int DW          = 8,
  parameter int UNLOCK_RDS  = 4,
  parameter int CW          = $clog2(UNLOCK_RDS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_hit,
  input  logic          wr_hit,
  input  logic          at_mask,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] mask_q,
  output logic [DW-1:0] hide_q,
  output logic [DW-1:0] port_rdata,
  output logic          armed,
  output logic [CW-1:0] cnt_q
);

  localparam logic [CW-1:0] ARM_CNT = CW'(UNLOCK_RDS);

  logic [CW-1:0] cnt_d;
  logic          cnt_en;
  logic          mask_en;
  logic          hide_en;

  assign armed = (cnt_q == ARM_CNT);

  // read-count sequencer: next state
  always_comb begin
    cnt_en = rd_hit || wr_hit;
    cnt_d  = cnt_q;
    if (wr_hit) begin
      cnt_d = '0;
    end else if (rd_hit) begin
      if (!at_mask) begin
        cnt_d = '0;
      end else if (!armed) begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // write steering between the mask and the hidden byte
  always_comb begin
    mask_en = wr_hit && at_mask && !armed;
    hide_en = wr_hit && at_mask && armed;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_en) begin
      mask_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hide_q <= '0;
    end else if (hide_en) begin
      hide_q <= wdata;
    end
  end

  always_comb begin
    port_rdata = armed ? hide_q : mask_q;
  end

endmodule

// File: rtl/disp_depth_dec.sv
module disp_depth_dec
  import disp_regport_pkg::*;
(
  input  logic [7:0] code,
  output logic [1:0] depth,
  output logic       err
);

  always_comb begin
    err   = 1'b0;
    depth = DEPTH_8;
    case (code[4:0])
      CODE_8BPP:  depth = DEPTH_8;
      CODE_16BPP: depth = DEPTH_16;
      CODE_24BPP: depth = DEPTH_24;
      CODE_32BPP: depth = DEPTH_32;
      default: begin
        depth = DEPTH_8;
        err   = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/disp_regport.sv
module disp_regport
  import disp_regport_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int SEQ_N      = 8,
  parameter int CRT_N      = 32,
  parameter int GFX_N      = 16,
  parameter int DEPTH_REG  = 7,
  parameter int UNLOCK_RDS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic [7:0]        pal_mask,
  output logic [7:0]        pix_mode,
  output logic [1:0]        pix_depth,
  output logic              depth_err
);

  localparam int UNL_CW = $clog2(UNLOCK_RDS + 1);

  logic              rst_sync_n;
  port_e             port;
  logic              wr_eff;
  logic              rd_eff;
  logic [7:0]        seq_idx, seq_dat, seq_tap;
  logic [7:0]        crt_idx, crt_dat, crt_tap_unused;
  logic [7:0]        gfx_idx, gfx_dat, gfx_tap_unused;
  logic [7:0]        mask_rdata;
  logic              unl_armed;
  logic [UNL_CW-1:0] unl_cnt;
  logic [7:0]        rd_mux;

  disp_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // access qualification: a write wins over a read in the same cycle
  always_comb begin
    port   = decode_port(8'(bus_addr));
    wr_eff = bus_wr;
    rd_eff = bus_rd && !bus_wr;
  end

  disp_idx_bank #(.N(SEQ_N), .DW(DW), .TAP(DEPTH_REG)) u_seq (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .idx_we (wr_eff && (port == PORT_SEQ_IDX)),
    .dat_we (wr_eff && (port == PORT_SEQ_DAT)),
    .wdata  (bus_wdata),
    .idx_q  (seq_idx),
    .dat_q  (seq_dat),
    .tap_q  (seq_tap)
  );

  disp_idx_bank #(.N(CRT_N), .DW(DW), .TAP(0)) u_crt (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .idx_we (wr_eff && (port == PORT_CRT_IDX)),
    .dat_we (wr_eff && (port == PORT_CRT_DAT)),
    .wdata  (bus_wdata),
    .idx_q  (crt_idx),
    .dat_q  (crt_dat),
    .tap_q  (crt_tap_unused)
  );

  disp_idx_bank #(.N(GFX_N), .DW(DW), .TAP(0)) u_gfx (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .idx_we (wr_eff && (port == PORT_GFX_IDX)),
    .dat_we (wr_eff && (port == PORT_GFX_DAT)),
    .wdata  (bus_wdata),
    .idx_q  (gfx_idx),
    .dat_q  (gfx_dat),
    .tap_q  (gfx_tap_unused)
  );

  disp_mask_unit #(.DW(DW), .UNLOCK_RDS(UNLOCK_RDS), .CW(UNL_CW)) u_mask (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .rd_hit     (rd_eff),
    .wr_hit     (wr_eff),
    .at_mask    (port == PORT_MASK),
    .wdata      (bus_wdata),
    .mask_q     (pal_mask),
    .hide_q     (pix_mode),
    .port_rdata (mask_rdata),
    .armed      (unl_armed),
    .cnt_q      (unl_cnt)
  );

  disp_depth_dec u_depth (
    .code  (seq_tap),
    .depth (pix_depth),
    .err   (depth_err)
  );

  always_comb begin
    case (port)
      PORT_SEQ_IDX: rd_mux = seq_idx;
      PORT_SEQ_DAT: rd_mux = seq_dat;
      PORT_CRT_IDX: rd_mux = crt_idx;
      PORT_CRT_DAT: rd_mux = crt_dat;
      PORT_GFX_IDX: rd_mux = gfx_idx;
      PORT_GFX_DAT: rd_mux = gfx_dat;
      PORT_MASK:    rd_mux = mask_rdata;
      default:      rd_mux = 8'h00;
    endcase
    bus_rdata = rd_eff ? rd_mux : 8'h00;
  end

endmodule

// File: rtl/disp_regport_chk.sv
module disp_regport_chk #(
  parameter int ADDR_W = 5,
  parameter int CW     = 3,
  parameter int LIM    = 4
) (
  input logic              clk,
  input logic              rst_ok,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        seq_idx,
  input logic [CW-1:0]     unl_cnt,
  input logic              armed,
  input logic [7:0]        pal_mask,
  input logic [7:0]        pix_mode,
  input logic [1:0]        pix_depth,
  input logic              depth_err
);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_ok)
    int'(unl_cnt) <= LIM); // R4

  AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_ok)
    bus_wr |=> (unl_cnt == '0)); // R5

  AST_OTHER_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_ok)
    (bus_rd && !bus_wr && (int'(bus_addr) != 6)) |=> (unl_cnt == '0)); // R5

  AST_HIDDEN_GUARDED: assert property (@(posedge clk) disable iff (!rst_ok)
    !(bus_wr && (int'(bus_addr) == 6) && armed) |=> $stable(pix_mode)); // R4

  AST_MASK_HELD_ON_HIDDEN: assert property (@(posedge clk) disable iff (!rst_ok)
    (bus_wr && (int'(bus_addr) == 6) && armed) |=> ($stable(pal_mask) && (unl_cnt == '0))); // R6

  AST_IDX_LOAD: assert property (@(posedge clk) disable iff (!rst_ok)
    (bus_wr && (int'(bus_addr) == 4)) |=> (seq_idx == $past(bus_wdata))); // R1

  AST_DEPTH_32: assert property (@(posedge clk) disable iff (!rst_ok)
    (bus_wr && (int'(bus_addr) == 5) && (seq_idx == 8'd7) && (bus_wdata[4:0] == 5'h19))
      |=> ((pix_depth == 2'd3) && !depth_err)); // R8

  AST_BAD_CODE: assert property (@(posedge clk) disable iff (!rst_ok)
    (bus_wr && (int'(bus_addr) == 5) && (seq_idx == 8'd7) && (bus_wdata[4:0] == 5'h00))
      |=> (depth_err && (pix_depth == 2'd0))); // R9

endmodule

bind disp_regport disp_regport_chk #(.ADDR_W(ADDR_W), .CW(UNL_CW), .LIM(UNLOCK_RDS)) u_chk (
  .clk       (clk),
  .rst_ok    (rst_sync_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_wdata (bus_wdata),
  .seq_idx   (seq_idx),
  .unl_cnt   (unl_cnt),
  .armed     (unl_armed),
  .pal_mask  (pal_mask),
  .pix_mode  (pix_mode),
  .pix_depth (pix_depth),
  .depth_err (depth_err)
);

// File: tb/disp_regport_test.sv
module disp_regport_test;

  localparam int SEQ_N = 8;
  localparam int CRT_N = 32;
  localparam int GFX_N = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] pal_mask;
  logic [7:0] pix_mode;
  logic [1:0] pix_depth;
  logic       depth_err;

  int vectors = 0;
  int miscompares = 0;

  always #5 clk = ~clk;

  disp_regport #(.ADDR_W(5), .SEQ_N(SEQ_N), .CRT_N(CRT_N), .GFX_N(GFX_N)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pal_mask  (pal_mask),
    .pix_mode  (pix_mode),
    .pix_depth (pix_depth),
    .depth_err (depth_err)
  );

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
    @(posedge clk);
    #1 bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1; bus_wr = 1'b0;
    #1 d = bus_rdata;
    @(posedge clk);
    #1 bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int grp_size(input int g);
    return (g == 0) ? SEQ_N : (g == 1) ? CRT_N : GFX_N;
  endfunction
  function automatic logic [4:0] idx_port(input int g);
    return (g == 0) ? 5'h04 : (g == 1) ? 5'h14 : 5'h0E;
  endfunction
  function automatic logic [7:0] pat(input int g, input int i, input int k);
    return 8'((i * 37 + g * 91 + k * 113 + 5) & 8'hFF);
  endfunction

  function automatic int exp_depth(input logic [7:0] v);
    case (v[4:0])
      5'h11: return 0;
      5'h17: return 1;
      5'h15: return 2;
      5'h19: return 3;
      default: return 0;
    endcase
  endfunction
  function automatic int exp_err(input logic [7:0] v);
    return (v[4:0] == 5'h11 || v[4:0] == 5'h17 || v[4:0] == 5'h15 || v[4:0] == 5'h19) ? 0 : 1;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog all-reqs actual=hung expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [7:0] mask_exp;
    logic [7:0] mode_exp;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10: reset state at the outputs
    check("R10 mask", pal_mask, 0);
    check("R10 mode", pix_mode, 0);
    check("R10 err", depth_err, 1);
    check("R10 depth", pix_depth, 0);
    // R10/R11: every offset reads zero after reset
    for (int a = 0; a < 32; a++) begin
      rd(5'(a), d);
      check("R10 R11 offset read", d, 0);
    end
    for (int g = 0; g < 3; g++) begin
      for (int i = 0; i < grp_size(g); i++) begin
        wr(idx_port(g), 8'(i));
        rd(idx_port(g) + 5'd1, d);
        check("R10 register zero", d, 0);
      end
    end

    // R1: full index sweep on every index port
    for (int g = 0; g < 3; g++) begin
      for (int v = 0; v < 256; v++) begin
        wr(idx_port(g), 8'(v));
        rd(idx_port(g), d);
        check("R1 index readback", d, v);
      end
    end

    // R2: two patterns, all written first then all read back
    for (int k = 0; k < 2; k++) begin
      for (int g = 0; g < 3; g++) begin
        for (int i = 0; i < grp_size(g); i++) begin
          wr(idx_port(g), 8'(i));
          wr(idx_port(g) + 5'd1, pat(g, i, k));
        end
      end
      for (int g = 0; g < 3; g++) begin
        for (int i = 0; i < grp_size(g); i++) begin
          wr(idx_port(g), 8'(i));
          rd(idx_port(g) + 5'd1, d);
          check("R2 data readback", d, pat(g, i, k));
        end
      end
    end

    // R3: out-of-range index ignores writes and reads zero
    for (int g = 0; g < 3; g++) begin
      wr(idx_port(g), 8'(grp_size(g)));
      wr(idx_port(g) + 5'd1, 8'hAA);
      rd(idx_port(g) + 5'd1, d);
      check("R3 out-of-range read", d, 0);
      wr(idx_port(g), 8'hFF);
      wr(idx_port(g) + 5'd1, 8'h55);
      rd(idx_port(g) + 5'd1, d);
      check("R3 index 0xFF read", d, 0);
      for (int i = 0; i < grp_size(g); i++) begin
        wr(idx_port(g), 8'(i));
        rd(idx_port(g) + 5'd1, d);
        check("R3 no aliasing", d, pat(g, i, 1));
      end
    end

    // R8/R9: sweep every value of sequencer register 7
    wr(5'h04, 8'd7);
    for (int v = 0; v < 256; v++) begin
      wr(5'h05, 8'(v));
      @(negedge clk);
      check("R8 depth", pix_depth, exp_depth(8'(v)));
      check("R9 err", depth_err, exp_err(8'(v)));
      rd(5'h05, d);
      check("R2 reg7 readback", d, v);
    end

    // R4/R5/R7: read-count sweep before a mask-port write
    mask_exp = 8'h00;
    mode_exp = 8'h00;
    for (int n = 0; n < 7; n++) begin
      rd(5'h04, d);
      for (int r = 0; r < n; r++) begin
        rd(5'h06, d);
        check("R7 mask-port read", d, (r >= 4) ? mode_exp : mask_exp);
      end
      if (n >= 4) mode_exp = 8'(8'hC0 + n); else mask_exp = 8'(8'h30 + n);
      wr(5'h06, (n >= 4) ? 8'(8'hC0 + n) : 8'(8'h30 + n));
      @(negedge clk);
      check("R4 mask after sweep", pal_mask, mask_exp);
      check("R4 mode after sweep", pix_mode, mode_exp);
    end

    // R6: next mask write after a hidden write goes to the mask
    for (int r = 0; r < 4; r++) rd(5'h06, d);
    wr(5'h06, 8'hC5);
    mode_exp = 8'hC5;
    wr(5'h06, 8'h5A);
    mask_exp = 8'h5A;
    @(negedge clk);
    check("R6 mask", pal_mask, mask_exp);
    check("R6 mode", pix_mode, mode_exp);

    // R5: breakers inserted after three reads
    for (int b = 0; b < 4; b++) begin
      for (int r = 0; r < 3; r++) rd(5'h06, d);
      case (b)
        0: rd(5'h14, d);
        1: wr(5'h0E, 8'h03);
        2: begin
          @(negedge clk);
          bus_addr = 5'h06; bus_wdata = 8'h70; bus_wr = 1'b1; bus_rd = 1'b1;
          #1 check("R12 rdata on both strobes", bus_rdata, 0);
          @(posedge clk);
          #1 begin bus_wr = 1'b0; bus_rd = 1'b0; end
          mask_exp = 8'h70;
        end
        default: idle(5);
      endcase
      rd(5'h06, d);
      if (b == 3) mode_exp = 8'(8'hB0 + b); else mask_exp = 8'(8'hB0 + b);
      wr(5'h06, 8'(8'hB0 + b));
      @(negedge clk);
      check("R5 breaker mask", pal_mask, mask_exp);
      check("R5 breaker mode", pix_mode, mode_exp);
    end

    // R5: armed state dropped by another-port read
    for (int r = 0; r < 4; r++) rd(5'h06, d);
    rd(5'h05, d);
    rd(5'h06, d);
    check("R5 disarmed read", d, mask_exp);
    wr(5'h06, 8'h11);
    mask_exp = 8'h11;
    @(negedge clk);
    check("R5 disarmed mask", pal_mask, mask_exp);
    check("R5 disarmed mode", pix_mode, mode_exp);

    // R12: four both-strobe cycles count as writes only
    for (int r = 0; r < 4; r++) begin
      @(negedge clk);
      bus_addr = 5'h06; bus_wdata = 8'(8'h20 + r); bus_wr = 1'b1; bus_rd = 1'b1;
      @(posedge clk);
      #1 begin bus_wr = 1'b0; bus_rd = 1'b0; end
    end
    mask_exp = 8'h23;
    wr(5'h06, 8'h99);
    mask_exp = 8'h99;
    @(negedge clk);
    check("R12 mask", pal_mask, mask_exp);
    check("R12 mode", pix_mode, mode_exp);

    // R11: no read strobe gives zero read data
    @(negedge clk);
    bus_addr = 5'h04;
    #1 check("R11 idle rdata", bus_rdata, 0);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule